// File: doc/BRIEF.md
# H-Bridge Control-Mode Decoder

This block turns two control bits and a wake request into gate-drive commands for the two half-bridges of an H-bridge. Each half-bridge command is one of three states: off (both switches open), low-side on, or high-side on. A two-bit mode code says how the control bits are read. There are three schemes: a direction-plus-enable scheme, a two-input PWM scheme, and a scheme where each control bit drives its own half-bridge. The code is sampled only when the block starts to wake from sleep.

A power sequencer counts a wake delay and a sleep delay, each a parameter in clock cycles. The bridge stays off until the wake delay has elapsed. Then the `active` status rises, and from that cycle the decoded commands appear with one register of latency. When the wake request falls, the bridge goes off on the next edge and a sleep countdown starts. The wake request is not looked at again until that countdown is done. A separate flag, `reg_allow`, tells downstream current-regulation logic whether it may act. It is high only while the bridge is active in one of the two bridge-coupled schemes.

Top module: `hbridge_mode_decoder`

## Requirements
- R1: While reset is low and on the first edge after it, both drive commands are off (00), and `active` and `reg_allow` are low.
- R2: Mode code 00 selects direction/enable, 01 selects two-input PWM, and any code with bit 1 set (10 or 11, the floating level) selects independent half-bridge. The code is captured on the edge where `wake_req` is seen high while the block is asleep.
- R3: A change of `mode_pin` at any other time has no effect on the decoding until the next capture.
- R4: `active` rises WAKE_CYC edges after the capturing edge. Both commands stay off until that edge, and they are decoded from that edge on.
- R5: An edge that samples `wake_req` low while active drives both commands off and `active` low. Over the next SLEEP_CYC edges the block ignores `wake_req`, and only then may a new wake start.
- R6: Direction/enable (`ctl_a` = enable, `ctl_b` = direction): enable 0 drives both low. Enable 1 with direction 1 drives A high and B low. Enable 1 with direction 0 drives A low and B high.
- R7: Two-input PWM, with {ctl_a,ctl_b} read as a 2-bit value: 00 turns both off, 01 drives A low and B high, 10 drives A high and B low, 11 drives both low.
- R8: Independent mode: each control bit drives its own half-bridge, 0 giving low-side on and 1 giving high-side on.
- R9: `reg_allow` is high exactly when `active` is high and the captured mode is not independent.
- R10: A command is encoded 00 off, 01 low-side on, 10 high-side on. Code 11 never appears.
- R11: If `wake_req` falls before the wake count completes, the block returns to sleep on that edge without becoming active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wake_req | input | 1 | 1 requests operation, 0 requests sleep |
| ctl_a | input | 1 | First control bit (enable / IN-A) |
| ctl_b | input | 1 | Second control bit (direction / IN-B) |
| mode_pin | input | 2 | Encoded three-level mode-select value |
| drv_a | output | 2 | Command for half-bridge A |
| drv_b | output | 2 | Command for half-bridge B |
| active | output | 1 | Wake delay elapsed, bridge decoding |
| reg_allow | output | 1 | Current regulation permitted |

## Verification
The hardest situations to reach are the ones where `mode_pin` or `wake_req` move at times when they must be ignored. Examples are a mode change mid-operation, a wake request that arrives during the sleep countdown, and a wake that is withdrawn partway through the wake count. Directed phases place these events at chosen offsets inside short wake and sleep windows. After that, random phases toggle `wake_req` rarely and `mode_pin` often, so that captures land with every code, 11 included. A cycle-level model of the requirements predicts every output on every cycle.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

    typedef enum logic [1:0] {
        DRV_OFF = 2'b00,
        DRV_LO  = 2'b01,
        DRV_HI  = 2'b10
    } drv_e;

    typedef enum logic [1:0] {
        MODE_DIREN = 2'b00,
        MODE_PWM   = 2'b01,
        MODE_INDEP = 2'b10
    } mode_e;

    typedef enum logic [1:0] {
        PS_ASLEEP   = 2'b00,
        PS_WAKING   = 2'b01,
        PS_ACTIVE   = 2'b10,
        PS_SLEEPING = 2'b11
    } pwr_e;

    // Bit 1 set marks the floating level; otherwise bit 0 picks low/high.
    function automatic mode_e pin_to_mode(input logic [1:0] pin);
        if (pin[1])      return MODE_INDEP;
        else if (pin[0]) return MODE_PWM;
        else             return MODE_DIREN;
    endfunction

    function automatic drv_e bit_to_drv(input logic b);
        return b ? DRV_HI : DRV_LO;
    endfunction

endpackage

// File: rtl/hbd_decode.sv
module hbd_decode
    import hbd_pkg::*;
(
    input  mode_e mode,
    input  logic  ctl_a,
    input  logic  ctl_b,
    output drv_e  drv_a,
    output drv_e  drv_b
);

    always_comb begin
        drv_a = DRV_OFF;
        drv_b = DRV_OFF;
        unique case (mode)
            MODE_DIREN: begin
                if (!ctl_a) begin
                    drv_a = DRV_LO;
                    drv_b = DRV_LO;
                end else begin
                    drv_a = ctl_b ? DRV_HI : DRV_LO;
                    drv_b = ctl_b ? DRV_LO : DRV_HI;
                end
            end
            MODE_PWM: begin
                unique case ({ctl_a, ctl_b})
                    2'b00: begin drv_a = DRV_OFF; drv_b = DRV_OFF; end
                    2'b01: begin drv_a = DRV_LO;  drv_b = DRV_HI;  end
                    2'b10: begin drv_a = DRV_HI;  drv_b = DRV_LO;  end
                    default: begin drv_a = DRV_LO; drv_b = DRV_LO; end
                endcase
            end
            default: begin
                drv_a = bit_to_drv(ctl_a);
                drv_b = bit_to_drv(ctl_b);
            end
        endcase
    end

endmodule

// File: rtl/hbd_power_seq.sv
module hbd_power_seq
    import hbd_pkg::*;
#(
    parameter int WAKE_CYC  = 250000,
    parameter int SLEEP_CYC = 250000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wake_req,
    input  logic [1:0] mode_pin,
    output logic       run_nxt,
    output mode_e      mode_nxt,
    output logic       active_q
);

    localparam int MAXC = (WAKE_CYC > SLEEP_CYC) ? WAKE_CYC : SLEEP_CYC;
    localparam int CW   = (MAXC > 1) ? $clog2(MAXC + 1) : 1;
    localparam logic [CW-1:0] WAKE_LAST  = CW'(WAKE_CYC - 1);
    localparam logic [CW-1:0] SLEEP_LAST = CW'(SLEEP_CYC - 1);

    typedef struct packed {
        pwr_e          state;
        logic [CW-1:0] cnt;
        mode_e         mode;
    } seq_s;

    seq_s seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            PS_ASLEEP: begin
                if (wake_req) begin
                    seq_d.state = PS_WAKING;
                    seq_d.cnt   = '0;
                    seq_d.mode  = pin_to_mode(mode_pin);
                end
            end
            PS_WAKING: begin
                if (!wake_req) begin
                    seq_d.state = PS_ASLEEP;
                    seq_d.cnt   = '0;
                end else if (seq_q.cnt == WAKE_LAST) begin
                    seq_d.state = PS_ACTIVE;
                    seq_d.cnt   = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            PS_ACTIVE: begin
                if (!wake_req) begin
                    seq_d.state = PS_SLEEPING;
                    seq_d.cnt   = '0;
                end
            end
            default: begin
                if (seq_q.cnt == SLEEP_LAST) begin
                    seq_d.state = PS_ASLEEP;
                    seq_d.cnt   = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: PS_ASLEEP, cnt: '0, mode: MODE_DIREN};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign run_nxt  = (seq_d.state == PS_ACTIVE);
    assign mode_nxt = seq_d.mode;
    assign active_q = (seq_q.state == PS_ACTIVE);

    // R3: captured mode never moves while the bridge stays active
    p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && $past(active_q)) |-> $stable(seq_q.mode));

    // R11: withdrawing the wake request during the count returns to sleep
    p_wake_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == PS_WAKING && !wake_req) |=> (seq_q.state == PS_ASLEEP));

    // R5: the sleep countdown cannot be left early for a new wake
    p_sleep_no_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == PS_SLEEPING) |=> (seq_q.state != PS_WAKING));

endmodule

// File: rtl/hbridge_mode_decoder.sv
module hbridge_mode_decoder
    import hbd_pkg::*;
#(
    parameter int WAKE_CYC  = 250000,
    parameter int SLEEP_CYC = 250000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wake_req,
    input  logic       ctl_a,
    input  logic       ctl_b,
    input  logic [1:0] mode_pin,
    output logic [1:0] drv_a,
    output logic [1:0] drv_b,
    output logic       active,
    output logic       reg_allow
);

    typedef struct packed {
        drv_e a;
        drv_e b;
        logic reg_ok;
    } out_s;

    logic  run_nxt;
    mode_e mode_nxt;
    logic  active_q;
    drv_e  dec_a, dec_b;
    out_s  out_d, out_q;

    hbd_power_seq #(
        .WAKE_CYC (WAKE_CYC),
        .SLEEP_CYC(SLEEP_CYC)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wake_req(wake_req),
        .mode_pin(mode_pin),
        .run_nxt (run_nxt),
        .mode_nxt(mode_nxt),
        .active_q(active_q)
    );

    hbd_decode u_dec (
        .mode (mode_nxt),
        .ctl_a(ctl_a),
        .ctl_b(ctl_b),
        .drv_a(dec_a),
        .drv_b(dec_b)
    );

    always_comb begin
        out_d.a      = run_nxt ? dec_a : DRV_OFF;
        out_d.b      = run_nxt ? dec_b : DRV_OFF;
        out_d.reg_ok = run_nxt && (mode_nxt != MODE_INDEP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{a: DRV_OFF, b: DRV_OFF, reg_ok: 1'b0};
        end else begin
            out_q <= out_d;
        end
    end

    assign drv_a     = out_q.a;
    assign drv_b     = out_q.b;
    assign active    = active_q;
    assign reg_allow = out_q.reg_ok;

    // R5: a sampled sleep request turns the bridge off on the next edge
    p_sleep_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_req |=> (drv_a == DRV_OFF && drv_b == DRV_OFF && !active));

    // R10: the unused command code never appears
    p_code_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_a != 2'b11) && (drv_b != 2'b11));

    // R9: regulation permission implies an active bridge
    p_reg_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_allow |-> active);

    // R4: an inactive bridge carries no drive
    p_idle_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (drv_a == DRV_OFF && drv_b == DRV_OFF));

    // R6: in coupled modes both high-sides are never on together
    p_no_shoot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_allow |-> !(drv_a == DRV_HI && drv_b == DRV_HI));

endmodule

// File: tb/sim_hbridge_mode_decoder.sv
`timescale 1ns/1ps
module sim_hbridge_mode_decoder;

    localparam int WAKE_CYC  = 8;
    localparam int SLEEP_CYC = 6;
    localparam int LIMIT     = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wake_req = 1'b0;
    logic       ctl_a = 1'b0;
    logic       ctl_b = 1'b0;
    logic [1:0] mode_pin = 2'b00;
    logic [1:0] drv_a, drv_b;
    logic       active, reg_allow;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    string tag_force = "";

    always #2 clk = ~clk;

    hbridge_mode_decoder #(.WAKE_CYC(WAKE_CYC), .SLEEP_CYC(SLEEP_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .ctl_a(ctl_a),
        .ctl_b(ctl_b), .mode_pin(mode_pin), .drv_a(drv_a), .drv_b(drv_b),
        .active(active), .reg_allow(reg_allow)
    );

    // Model state: 0 asleep, 1 waking, 2 active, 3 sleep countdown
    int         m_st = 0;
    int         m_cnt = 0;
    int         m_mode = 0;   // 0 dir/en, 1 pwm, 2 independent
    logic [1:0] e_a = 2'b00, e_b = 2'b00;
    logic       e_act = 1'b0, e_reg = 1'b0;

    function automatic int code_to_mode(input logic [1:0] p);
        if (p[1]) return 2;     // R2: 10 and 11 select independent
        if (p[0]) return 1;
        return 0;
    endfunction

    function automatic logic [3:0] table_out(input int md, input logic a, input logic b);
        // returns {A, B}: 00 off, 01 low, 10 high (R10)
        case (md)
            0: return !a ? 4'b0101 : (b ? 4'b1001 : 4'b0110);          // R6
            1: case ({a, b})                                            // R7
                   2'b00: return 4'b0000;
                   2'b01: return 4'b0110;
                   2'b10: return 4'b1001;
                   default: return 4'b0101;
               endcase
            default: return {(a ? 2'b10 : 2'b01), (b ? 2'b10 : 2'b01)}; // R8
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st <= 0; m_cnt <= 0; m_mode <= 0;
            e_a <= 2'b00; e_b <= 2'b00; e_act <= 1'b0; e_reg <= 1'b0;
        end else begin
            automatic int ns = m_st;
            automatic int nc = m_cnt;
            automatic int nm = m_mode;
            automatic logic [3:0] t;
            case (m_st)
                0: if (wake_req) begin ns = 1; nc = 0; nm = code_to_mode(mode_pin); end
                1: if (!wake_req) begin ns = 0; nc = 0; end            // R11
                   else if (m_cnt == WAKE_CYC - 1) begin ns = 2; nc = 0; end
                   else nc = m_cnt + 1;
                2: if (!wake_req) begin ns = 3; nc = 0; end
                default: if (m_cnt == SLEEP_CYC - 1) begin ns = 0; nc = 0; end
                         else nc = m_cnt + 1;
            endcase
            t = table_out(nm, ctl_a, ctl_b);
            m_st <= ns; m_cnt <= nc; m_mode <= nm;
            e_act <= (ns == 2);
            e_a   <= (ns == 2) ? t[3:2] : 2'b00;
            e_b   <= (ns == 2) ? t[1:0] : 2'b00;
            e_reg <= (ns == 2) && (nm != 2);
        end
    end

    task automatic check(input string req, input string what,
                         input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual %b expected %b",
                     req, what, cyc, act, exp);
        end
    endtask

    task automatic check_all();
        string rq;
        if (tag_force != "") rq = tag_force;
        else if (!e_act)     rq = (m_st == 3) ? "R5" : "R4";
        else if (m_mode == 0) rq = "R6";
        else if (m_mode == 1) rq = "R7";
        else                  rq = "R8";
        check(rq, "drv_a", drv_a, e_a);
        check(rq, "drv_b", drv_b, e_b);
        check("R4", "active", {1'b0, active}, {1'b0, e_act});
        check("R9", "reg_allow", {1'b0, reg_allow}, {1'b0, e_reg});
        check("R10", "code_a", {1'b0, drv_a == 2'b11}, 2'b00);
    endtask

    // One cycle: sample at negedge, then drive new inputs
    task automatic step(input logic w, input logic a, input logic b, input logic [1:0] m);
        @(negedge clk);
        cyc++;
        check_all();
        wake_req = w; ctl_a = a; ctl_b = b; mode_pin = m;
    endtask

    initial begin
        #(LIMIT * 4);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic w;
        void'($urandom(32'h5eed_0042));
        // R1: reset state
        repeat (3) @(negedge clk);
        tag_force = "R1";
        check("R1", "drv_a", drv_a, 2'b00);
        check("R1", "drv_b", drv_b, 2'b00);
        check("R1", "active", {1'b0, active}, 2'b00);
        check("R1", "reg_allow", {1'b0, reg_allow}, 2'b00);
        rst_n = 1'b1;
        step(0, 1, 1, 2'b01);
        tag_force = "";

        // R2 + R4: wake with dir/en, outputs off until count done
        tag_force = "R2";
        step(1, 1, 1, 2'b00);
        for (int i = 0; i < WAKE_CYC + 3; i++) step(1, 1, 1, 2'b00);
        tag_force = "R3";
        // mode pin moves while active: still dir/en, ctl 00 -> brake
        for (int i = 0; i < 4; i++) step(1, 0, 0, 2'b01);
        for (int i = 0; i < 4; i++) step(1, 1, 0, 2'b10);
        // R5: sleep, wake requested during countdown with PWM code
        tag_force = "R5";
        step(0, 1, 0, 2'b01);
        step(0, 1, 0, 2'b01);
        for (int i = 0; i < SLEEP_CYC + WAKE_CYC + 4; i++) step(1, 1, 0, 2'b01);
        // R7 coast while active in PWM
        tag_force = "R7";
        step(1, 0, 0, 2'b00);
        step(1, 0, 0, 2'b00);
        // R11: abort partway through the wake count
        tag_force = "R11";
        step(0, 0, 0, 2'b11);
        for (int i = 0; i < SLEEP_CYC + 2; i++) step(0, 0, 0, 2'b11);
        step(1, 1, 0, 2'b11);
        for (int i = 0; i < WAKE_CYC / 2; i++) step(1, 1, 0, 2'b11);
        step(0, 1, 0, 2'b11);
        step(0, 1, 0, 2'b11);
        step(1, 1, 0, 2'b11);
        for (int i = 0; i < WAKE_CYC + 3; i++) step(1, 1, 0, 2'b00);
        tag_force = "";

        // Random phase
        w = 1'b1;
        for (int i = 0; i < 20000; i++) begin
            if ($urandom_range(0, 39) == 0) w = ~w;
            step(w, 1'($urandom), 1'($urandom), 2'($urandom));
        end
        step(w, 0, 0, 2'b00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule